// File: doc/BRIEF.md
# Low-Power Wake Source Controller

The block watches a small set of wake lines (external pins or peripheral event lines) while the system sits in one of two low-power depths, and raises a single one-cycle wake request toward the power mode controller when one of them fires. Every line is first brought into the clock domain through a two-flop synchroniser. Each line then has its own enable bit, polarity bit and 8-bit trigger code. The trigger code selects rising-edge, falling-edge, both-edge, high-level or low-level detection, or marks the line as ignored.

The sleep depth decides which lines may wake the system. In the lighter depth ("deep sleep") the lines marked hibernate-only are masked off; by default this is the top line. In the deepest depth ("hibernate") every enabled line counts. Lines that fire while eligible set sticky bits in a status register, which software clears by writing ones.

A flat register port gives access to the enable, polarity, status and trigger-code registers. It is a write strobe with address and data, plus a combinational read. Bits above the source count always read as zero.

Top module: `wake_src_ctrl`

## Requirements
- R1: Each wake input passes through two synchronising flops. A qualifying change presented before rising edge E0 sets its status bit and `wake_req` on edge E2, and not earlier.
- R2: Each source has an 8-bit trigger code. 0x01 fires on a rising edge, 0x02 on a falling edge, 0x03 on either edge, 0x04 while the line is high and 0x08 while it is low. The code of source k sits in word 3+k/4, bits 8*(k%4)+7 down to 8*(k%4).
- R3: Code 0xF0 makes its source ignored, and so does any code not listed in R2. After reset every code reads 0xF0.
- R4: Polarity bit k (word 1) set to 1 inverts input k before detection. Polarity 0 passes the input unchanged.
- R5: A source whose enable bit (word 0) is 0 never sets status and never causes a wake request.
- R6: `lp_mode` is encoded 0 run, 1 deep sleep, 2 hibernate, and 3 behaves as run. In run no source fires. In deep sleep sources 0 to 6 are eligible. In hibernate all eight sources are eligible.
- R7: Every source that fires in a cycle sets its status bit, and status bits stay set until cleared.
- R8: Writing word 2 clears each status bit written as 1 and leaves bits written as 0 alone. A source firing in the same cycle as the clear keeps its bit set.
- R9: `wake_req` is high for exactly one cycle. It pulses only when a source fires while the status register, after any clear in that cycle, holds no set bit.
- R10: Words 0, 1 and 2 hold one bit per source in bits 7..0. Their bits 31..8 read zero and ignore writes. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_in | input | 8 | Raw asynchronous wake lines, one per source |
| lp_mode | input | 2 | Current power depth: 0 run, 1 deep sleep, 2 hibernate |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| wake_req | output | 1 | One-cycle wake request to the power mode controller |
| wake_status | output | 8 | Latched status, one bit per source |

## Verification
The hardest case to reach is a clear of the status register landing in the same cycle as a new firing of a level-triggered line. That cycle must both keep the bit and issue a fresh request.

The bench reaches it by holding a high-level source active and writing the clear while the line stays asserted. It also sweeps every source against every trigger code, both polarities, each power depth and the enable bit. In each sweep run a fixed high-then-low pulse is applied, and the expected status and request count are derived arithmetically from the effective levels in each phase.

// File: rtl/wake_pkg.sv
package wake_pkg;

    typedef enum logic [1:0] {
        LP_RUN  = 2'd0,
        LP_DEEP = 2'd1,
        LP_HIB  = 2'd2
    } lp_mode_e;

    localparam logic [7:0] TRIG_RISE   = 8'h01;
    localparam logic [7:0] TRIG_FALL   = 8'h02;
    localparam logic [7:0] TRIG_BOTH   = 8'h03;
    localparam logic [7:0] TRIG_HIGH   = 8'h04;
    localparam logic [7:0] TRIG_LOW    = 8'h08;
    localparam logic [7:0] TRIG_IGNORE = 8'hF0;

    localparam int ADDR_EN    = 0;
    localparam int ADDR_POL   = 1;
    localparam int ADDR_STAT  = 2;
    localparam int ADDR_TRIG0 = 3;

    typedef struct packed {
        logic       en;
        logic       pol;
        logic [7:0] trig;
    } src_cfg_t;

    // evaluate one trigger code against the effective current/previous level
    function automatic logic trig_hit(logic [7:0] code, logic cur, logic prv);
        case (code)
            TRIG_RISE: return cur & ~prv;
            TRIG_FALL: return ~cur & prv;
            TRIG_BOTH: return cur ^ prv;
            TRIG_HIGH: return cur;
            TRIG_LOW:  return ~cur;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic src_eligible(lp_mode_e m, logic hib_only);
        return (m == LP_HIB) || ((m == LP_DEEP) && !hib_only);
    endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] cur,
    output logic [N-1:0] prv
);
    logic [N-1:0] stage1;

    for (genvar k = 0; k < N; k++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[k] <= 1'b0;
                cur[k]    <= 1'b0;
                prv[k]    <= 1'b0;
            end else begin
                stage1[k] <= raw[k];
                cur[k]    <= stage1[k];
                prv[k]    <= cur[k];
            end
        end
    end

endmodule

// File: rtl/wake_detect.sv
module wake_detect
    import wake_pkg::*;
#(
    parameter int             N        = 8,
    parameter logic [N-1:0]   HIB_ONLY = 8'h80
) (
    input  logic [N-1:0]           cur,
    input  logic [N-1:0]           prv,
    input  src_cfg_t [N-1:0]       cfg,
    input  lp_mode_e               mode,
    output logic [N-1:0]           hit
);
    for (genvar k = 0; k < N; k++) begin : g_src
        logic eff_cur;
        logic eff_prv;
        assign eff_cur = cur[k] ^ cfg[k].pol;
        assign eff_prv = prv[k] ^ cfg[k].pol;
        assign hit[k]  = cfg[k].en
                       & src_eligible(mode, HIB_ONLY[k])
                       & trig_hit(cfg[k].trig, eff_cur, eff_prv);
    end

endmodule

// File: rtl/wake_regs.sv
module wake_regs
    import wake_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [N-1:0]      hit,
    output src_cfg_t [N-1:0]  cfg,
    output logic [N-1:0]      status,
    output logic              req
);
    logic [N-1:0]      en_q, pol_q, stat_q;
    logic [N-1:0][7:0] trig_q;
    logic [N-1:0]      clr, kept, stat_n;
    logic              req_q, req_n;

    always_comb begin
        clr    = (we && addr == AW'(ADDR_STAT)) ? wdata[N-1:0] : '0;
        kept   = stat_q & ~clr;
        stat_n = kept | hit;
        req_n  = (|hit) && (kept == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pol_q  <= '0;
            stat_q <= '0;
            req_q  <= 1'b0;
        end else begin
            if (we && addr == AW'(ADDR_EN))  en_q  <= wdata[N-1:0];
            if (we && addr == AW'(ADDR_POL)) pol_q <= wdata[N-1:0];
            stat_q <= stat_n;
            req_q  <= req_n;
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_trig
        localparam int WORD = ADDR_TRIG0 + k / 4;
        localparam int LSB  = 8 * (k % 4);
        always_ff @(posedge clk) begin
            if (rst)
                trig_q[k] <= TRIG_IGNORE;
            else if (we && addr == AW'(WORD))
                trig_q[k] <= wdata[LSB +: 8];
        end
        assign cfg[k].en   = en_q[k];
        assign cfg[k].pol  = pol_q[k];
        assign cfg[k].trig = trig_q[k];
    end

    always_comb begin
        rdata = '0;
        case (addr)
            AW'(ADDR_EN):   rdata[N-1:0] = en_q;
            AW'(ADDR_POL):  rdata[N-1:0] = pol_q;
            AW'(ADDR_STAT): rdata[N-1:0] = stat_q;
            default: begin
                for (int k = 0; k < N; k++)
                    if (addr == AW'(ADDR_TRIG0 + k / 4))
                        rdata[8 * (k % 4) +: 8] = trig_q[k];
            end
        endcase
    end

    assign status = stat_q;
    assign req    = req_q;

endmodule

// File: rtl/wake_src_ctrl.sv
module wake_src_ctrl
    import wake_pkg::*;
#(
    parameter int                 NUM_SRC       = 8,
    parameter logic [NUM_SRC-1:0] HIB_ONLY_MASK = 8'h80,
    parameter int                 DATA_W        = 32,
    parameter int                 ADDR_W        = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] wake_in,
    input  logic [1:0]         lp_mode,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               wake_req,
    output logic [NUM_SRC-1:0] wake_status
);
    logic [NUM_SRC-1:0]     sync_cur, sync_prv, src_hit, src_en;
    src_cfg_t [NUM_SRC-1:0] src_cfg;
    lp_mode_e               mode_e;

    assign mode_e = lp_mode_e'(lp_mode);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_en
        assign src_en[k] = src_cfg[k].en;
    end

    wake_sync #(.N(NUM_SRC)) i_sync (
        .clk (clk),
        .rst (rst),
        .raw (wake_in),
        .cur (sync_cur),
        .prv (sync_prv)
    );

    wake_detect #(.N(NUM_SRC), .HIB_ONLY(HIB_ONLY_MASK)) i_detect (
        .cur  (sync_cur),
        .prv  (sync_prv),
        .cfg  (src_cfg),
        .mode (mode_e),
        .hit  (src_hit)
    );

    wake_regs #(.N(NUM_SRC), .DW(DATA_W), .AW(ADDR_W)) i_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .hit    (src_hit),
        .cfg    (src_cfg),
        .status (wake_status),
        .req    (wake_req)
    );

endmodule

// File: rtl/wake_src_ctrl_chk.sv
module wake_src_ctrl_chk #(
    parameter int                 NUM_SRC       = 8,
    parameter logic [NUM_SRC-1:0] HIB_ONLY_MASK = 8'h80,
    parameter int                 DATA_W        = 32,
    parameter int                 ADDR_W        = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         lp_mode,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               wake_req,
    input logic [NUM_SRC-1:0] wake_status,
    input logic [NUM_SRC-1:0] src_en
);
    a_r9_req_has_status: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (wake_status != '0));

    a_r6_no_req_in_run: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> ($past(lp_mode) == 2'd1 || $past(lp_mode) == 2'd2));

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr < ADDR_W'(3)) |-> (reg_rdata[DATA_W-1:NUM_SRC] == '0));

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
        a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (rst)
            $rose(wake_status[k]) |-> $past(src_en[k]));

        a_r8_clear_by_write: assert property (@(posedge clk) disable iff (rst)
            $fell(wake_status[k]) |->
                $past(reg_we && reg_addr == ADDR_W'(2) && reg_wdata[k]));

        if (HIB_ONLY_MASK[k]) begin : g_hib
            a_r6_hib_only: assert property (@(posedge clk) disable iff (rst)
                $rose(wake_status[k]) |-> ($past(lp_mode) == 2'd2));
        end
    end

endmodule

bind wake_src_ctrl wake_src_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .HIB_ONLY_MASK(HIB_ONLY_MASK),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .lp_mode     (lp_mode),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .wake_req    (wake_req),
    .wake_status (wake_status),
    .src_en      (src_en)
);

// File: tb/test_wake_src_ctrl.sv
module test_wake_src_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  wake_in = '0;
    logic [1:0]  lp_mode = 2'd0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wake_req;
    logic [7:0]  wake_status;

    int n_tests = 0;
    int n_fail  = 0;
    int pulses  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    wake_src_ctrl i_wake_src_ctrl (
        .clk(clk), .rst(rst), .wake_in(wake_in), .lp_mode(lp_mode),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wake_req(wake_req), .wake_status(wake_status)
    );

    always @(negedge clk) if (!rst && wake_req) pulses++;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        reg_addr = a;
        #1 check(tag, reg_rdata, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] codes [7] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h08, 8'hF0, 8'h05};
        int base;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // reset state
        #1 check("R9 reset wake_req", {31'd0, wake_req}, 32'd0);
        check("R7 reset status", {24'd0, wake_status}, 32'd0);
        rd(3'd3, 32'hF0F0F0F0, "R3 reset trig word 3");
        rd(3'd4, 32'hF0F0F0F0, "R3 reset trig word 4");

        // R10 reserved bits and unmapped words
        wr(3'd0, 32'hFFFFFFFF);
        rd(3'd0, 32'h000000FF, "R10 enable reserved");
        wr(3'd1, 32'hA5A5A5A5);
        rd(3'd1, 32'h000000A5, "R10 polarity reserved");
        rd(3'd5, 32'd0, "R10 addr 5");
        rd(3'd7, 32'd0, "R10 addr 7");
        // R2 field layout
        wr(3'd3, 32'h08040201);
        wr(3'd4, 32'hF0030201);
        rd(3'd3, 32'h08040201, "R2 trig word 3");
        rd(3'd4, 32'hF0030201, "R2 trig word 4");

        // exhaustive sweep: source x code x polarity x mode x enable
        for (int s = 0; s < 8; s++)
        for (int c = 0; c < 7; c++)
        for (int p = 0; p < 2; p++)
        for (int m = 0; m < 3; m++)
        for (int e = 0; e < 2; e++) begin
            logic [31:0] w3, w4;
            logic [7:0]  cd;
            bit act, hA, hB, hC, cum;
            cd = codes[c];
            w3 = 32'hF0F0F0F0; w4 = 32'hF0F0F0F0;
            if (s < 4) w3[8*s +: 8] = cd; else w4[8*(s-4) +: 8] = cd;
            lp_mode = 2'd0; wake_in = '0;
            wr(3'd0, e ? (32'd1 << s) : 32'd0);
            wr(3'd1, p ? (32'd1 << s) : 32'd0);
            wr(3'd3, w3);
            wr(3'd4, w4);
            idle(4);
            wr(3'd2, 32'hFF);
            act = (e == 1) && ((m == 2) || (m == 1 && s != 7));
            hA = (cd == 8'h04 && p == 1) || (cd == 8'h08 && p == 0);
            hB = (cd == 8'h01 && p == 0) || (cd == 8'h02 && p == 1) || cd == 8'h03
               || (cd == 8'h04 && p == 0) || (cd == 8'h08 && p == 1);
            hC = (cd == 8'h01 && p == 1) || (cd == 8'h02 && p == 0) || cd == 8'h03
               || (cd == 8'h04 && p == 1) || (cd == 8'h08 && p == 0);
            base = pulses;
            @(negedge clk) lp_mode = 2'(m);
            idle(5);
            cum = act && hA;
            check($sformatf("R3 R4 R5 R6 R7 phase A s%0d code %h p%0d m%0d e%0d", s, cd, p, m, e),
                  {24'd0, wake_status}, cum ? (32'd1 << s) : 32'd0);
            wake_in[s] = 1'b1;
            idle(5);
            cum = cum || (act && hB);
            check($sformatf("R2 R4 R6 R7 phase B s%0d code %h p%0d m%0d e%0d", s, cd, p, m, e),
                  {24'd0, wake_status}, cum ? (32'd1 << s) : 32'd0);
            wake_in[s] = 1'b0;
            idle(5);
            cum = cum || (act && hC);
            check($sformatf("R2 R5 R7 phase C s%0d code %h p%0d m%0d e%0d", s, cd, p, m, e),
                  {24'd0, wake_status}, cum ? (32'd1 << s) : 32'd0);
            check($sformatf("R9 pulse count s%0d code %h p%0d m%0d e%0d", s, cd, p, m, e),
                  pulses - base, cum ? 32'd1 : 32'd0);
            lp_mode = 2'd0;
            idle(2);
        end

        // R1 latency: high-level source 0, hibernate
        lp_mode = 2'd0; wake_in = '0;
        wr(3'd0, 32'h01); wr(3'd1, 32'h00);
        wr(3'd3, 32'hF0F0F004); wr(3'd4, 32'hF0F0F0F0);
        wr(3'd2, 32'hFF);
        @(negedge clk) lp_mode = 2'd2;
        idle(3);
        @(negedge clk) wake_in[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R1 status not before third edge", {24'd0, wake_status}, 32'd0);
        check("R1 no request before third edge", {31'd0, wake_req}, 32'd0);
        @(negedge clk);
        check("R1 status on third edge", {24'd0, wake_status}, 32'h01);
        check("R1 R9 request on third edge", {31'd0, wake_req}, 32'd1);
        @(negedge clk);
        check("R9 request lasts one cycle", {31'd0, wake_req}, 32'd0);

        // multi-source latching, partial clear, re-arm
        lp_mode = 2'd0; wake_in = '0;
        idle(4);
        wr(3'd0, 32'h7F);
        wr(3'd3, 32'h04040404); wr(3'd4, 32'h04040404);
        wr(3'd2, 32'hFF);
        @(negedge clk) lp_mode = 2'd2;
        idle(3);
        base = pulses;
        wake_in = 8'h0F;
        idle(5);
        check("R7 all firing sources latch", {24'd0, wake_status}, 32'h0F);
        check("R9 one pulse for simultaneous sources", pulses - base, 32'd1);
        wake_in = 8'h00;
        idle(4);
        wr(3'd2, 32'h01);
        rd(3'd2, 32'h0E, "R8 partial clear");
        wr(3'd2, 32'h0E);
        check("R8 full clear", {24'd0, wake_status}, 32'h00);
        check("R9 no pulse from clearing", pulses - base, 32'd1);
        wake_in = 8'h04;
        idle(5);
        check("R9 re-armed after clear", pulses - base, 32'd2);
        // clear while level still active: set wins and a new request issues
        wr(3'd2, 32'h04);
        idle(2);
        check("R8 set beats clear", {24'd0, wake_status}, 32'h04);
        check("R9 pulse on clear with active level", pulses - base, 32'd3);
        // lp_mode 3 behaves as run
        wake_in = 8'h00;
        @(negedge clk) lp_mode = 2'd0;
        idle(3);
        wr(3'd2, 32'hFF);
        @(negedge clk) lp_mode = 2'd3;
        wake_in = 8'h0F;
        idle(6);
        check("R6 mode 3 acts as run", {24'd0, wake_status}, 32'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule